// File: doc/BRIEF.md
# Reply Receiver Gate Controller

This block decides when reply video may enter the decoder after an interrogation has gone out. A decode-enable strobe, raised by the final interrogation pulse, closes any open window and starts a fixed post-interrogation delay. When that delay runs out, an internal gate flag is set, which opens the main receiver gate. In the same cycle a one-cycle trigger is sent to the read-delay stage that follows. The window stays open until any one of three terminate strobes arrives.

Each rising edge of video that passes the main gate starts a pulse shaper. The shaper drives a fixed-width pulse on a true output and the matching complement on a second output. In self-test, an encode-enable input drives the main gate instead of the gate flag. In the special mode the main gate stays shut, and video goes through an alternate path to an external output while the gate flag is set.

All inputs are synchronous to `clk`. The strobes are active-high. Video is a plain level signal, so the block has no flow control. Delay and pulse lengths are parameters given in clock cycles. The defaults are 18 and 7 cycles, which suit a 10 MHz clock.

Top module: `reply_gate_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `gate_open`, `read_trig`, `shp_true` and `ext_vid` are 0 and `shp_comp` is 1, provided the inputs are idle.
- R2: A `dec_en` strobe clears the gate flag, so the window is closed in the next cycle.
- R3: If `dec_en` is sampled at clock edge t and no further `dec_en` follows, the gate flag sets at edge t+DELAY_CYC. `read_trig` is high for exactly the one cycle after that edge.
- R4: A `dec_en` that arrives while the delay is still running restarts the full delay, counted from the new strobe.
- R5: A high on `term_line`, `term_count` or `term_timing` clears the gate flag at the next edge. When a terminate and the delay expiry fall in the same cycle, the flag stays clear. `read_trig` is still issued in that case.
- R6: When `self_test` is 1 and `mode_special` is 0, `gate_open` equals `enc_en` in the same cycle, whatever the state of the gate flag.
- R7: When `mode_special` is 1, `gate_open` is 0 and `ext_vid` equals `vid_in` AND the gate flag. Video in this mode never starts the shaper. When `mode_special` is 0, `ext_vid` is 0.
- R8: A 0-to-1 change of (`vid_in` AND `gate_open`) at edge e sets `shp_true` high for exactly SHAPE_CYC cycles, starting after edge e. `shp_comp` is always the inverse of `shp_true`.
- R9: Rising video edges that arrive while `shp_true` is high, including during its last cycle, are ignored and do not extend or restart the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_en | input | 1 | Decode-enable strobe from the final interrogation pulse |
| term_line | input | 1 | Line-drive terminate strobe |
| term_count | input | 1 | Reply-counter terminate strobe |
| term_timing | input | 1 | Timing-pulse terminate strobe |
| self_test | input | 1 | Selects self-test function |
| mode_special | input | 1 | Selects the special mode with the alternate video path |
| enc_en | input | 1 | Encode-enable level that drives the main gate in self-test |
| vid_in | input | 1 | Reply video level |
| gate_open | output | 1 | Main receiver gate is passing video |
| read_trig | output | 1 | One-cycle trigger for the read-delay stage |
| shp_true | output | 1 | Shaped video pulse, true polarity |
| shp_comp | output | 1 | Shaped video pulse, complement |
| ext_vid | output | 1 | Video on the alternate path in the special mode |

## Verification
The embedded properties check on every cycle that:
- a decode strobe or any terminate leaves the gate flag clear one cycle later;
- the flag only ever rises together with a read trigger;
- the special mode keeps the main gate shut;
- each one-shot falls only after reaching its full count.

Several behaviours depend on the sequence of stimulus, so only the bench scenarios can show them:
- the exact delay length after a decode strobe;
- the restart when a second strobe arrives mid-delay;
- a terminate winning over a same-cycle expiry;
- the shaper ignoring edges while its pulse is running.

The bench covers these with a cycle-level model under random traffic and with directed cases.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  // Width of a counter that must hold values 0 .. n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rgc_oneshot.sv
module rgc_oneshot #(
  parameter int unsigned LEN    = 18,
  parameter bit          RETRIG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active,
  output logic expire
);
  import rgc_pkg::*;
  localparam int unsigned CW = cnt_bits(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          start;
  logic          at_last;

  generate
    if (RETRIG) begin : g_retrig
      assign start = trig;
    end else begin : g_hold
      assign start = trig && !act_q;
    end
  endgenerate

  assign at_last = act_q && (cnt_q == LAST);
  assign expire  = at_last && !start;
  assign active  = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (at_last) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R3 / R8: the pulse ends only after the full length
  a_r8_full_length: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/rgc_gate_flag.sv
module rgc_gate_flag #(
  parameter int unsigned NTERM = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_clr,
  input  logic [NTERM-1:0] term,
  input  logic             set,
  output logic             q
);
  logic q_r;
  assign q = q_r;

  always_ff @(posedge clk) begin
    if (rst)                    q_r <= 1'b0;
    else if (dec_clr || |term)  q_r <= 1'b0;
    else if (set)               q_r <= 1'b1;
  end

  // R5: terminate wins, the flag is clear one cycle later
  a_r5_term_wins: assert property (@(posedge clk) disable iff (rst)
    (|term) |=> !q_r);
  // R2: decode strobe clears the flag
  a_r2_dec_clears: assert property (@(posedge clk) disable iff (rst)
    dec_clr |=> !q_r);
endmodule

// File: rtl/reply_gate_ctrl.sv
module reply_gate_ctrl #(
  parameter int unsigned DELAY_CYC = 18,
  parameter int unsigned SHAPE_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_en,
  input  logic term_line,
  input  logic term_count,
  input  logic term_timing,
  input  logic self_test,
  input  logic mode_special,
  input  logic enc_en,
  input  logic vid_in,
  output logic gate_open,
  output logic read_trig,
  output logic shp_true,
  output logic shp_comp,
  output logic ext_vid
);
  localparam int unsigned NTERM = 3;

  logic             dly_active;
  logic             dly_expire;
  logic             flag_q;
  logic             trig_q;
  logic [NTERM-1:0] term_vec;
  logic             main_en;
  logic             gated;
  logic             gated_q;
  logic             shp_start;
  logic             shp_active;
  logic             shp_expire;

  assign term_vec = {term_timing, term_count, term_line};

  // post-interrogation delay, restarted by every decode strobe
  rgc_oneshot #(.LEN(DELAY_CYC), .RETRIG(1'b1)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .trig   (dec_en),
    .active (dly_active),
    .expire (dly_expire)
  );

  rgc_gate_flag #(.NTERM(NTERM)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .dec_clr (dec_en),
    .term    (term_vec),
    .set     (dly_expire),
    .q       (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= dly_expire;
  end

  // main gate source: encode-enable in self-test, flag otherwise
  always_comb begin
    if (mode_special)   main_en = 1'b0;
    else if (self_test) main_en = enc_en;
    else                main_en = flag_q;
  end

  assign gated = vid_in && main_en;

  always_ff @(posedge clk) begin
    if (rst) gated_q <= 1'b0;
    else     gated_q <= gated;
  end

  assign shp_start = gated && !gated_q;

  rgc_oneshot #(.LEN(SHAPE_CYC), .RETRIG(1'b0)) u_shaper (
    .clk    (clk),
    .rst    (rst),
    .trig   (shp_start),
    .active (shp_active),
    .expire (shp_expire)
  );

  assign gate_open = main_en;
  assign read_trig = trig_q;
  assign shp_true  = shp_active;
  assign shp_comp  = !shp_active;
  assign ext_vid   = mode_special && flag_q && vid_in;

  // R3: the flag can only rise together with the read trigger
  a_r3_rise_with_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> trig_q);
  // R7: special mode never opens the main gate
  a_r7_special_shut: assert property (@(posedge clk) disable iff (rst)
    mode_special |-> !gate_open);
  // R8: shaper outputs stay complementary
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    shp_true != shp_comp);
  // R9: an edge during an active pulse does not restart it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (shp_active && shp_start && !shp_expire) |=> shp_active);
endmodule

// File: tb/reply_gate_ctrl_tb.sv
module reply_gate_ctrl_tb_top;
  localparam int CLK_PER = 100;
  localparam int DLY = 18;
  localparam int SHP = 7;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst;
  logic dec_en, term_line, term_count, term_timing;
  logic self_test, mode_special, enc_en, vid_in;
  logic gate_open, read_trig, shp_true, shp_comp, ext_vid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  int m_gate, m_dcnt, m_trig, m_shp, m_prevg;

  always #(CLK_PER/2) clk = ~clk;

  reply_gate_ctrl #(.DELAY_CYC(DLY), .SHAPE_CYC(SHP)) dut_i (
    .clk(clk), .rst(rst), .dec_en(dec_en), .term_line(term_line),
    .term_count(term_count), .term_timing(term_timing),
    .self_test(self_test), .mode_special(mode_special), .enc_en(enc_en),
    .vid_in(vid_in), .gate_open(gate_open), .read_trig(read_trig),
    .shp_true(shp_true), .shp_comp(shp_comp), .ext_vid(ext_vid)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_main();
    if (mode_special) return 0;
    if (self_test) return int'(enc_en);
    return m_gate;
  endfunction

  task automatic model_reset();
    m_gate = 0; m_dcnt = 0; m_trig = 0; m_shp = 0; m_prevg = 0;
  endtask

  task automatic model_check();
    chk(gate_open, exp_main() != 0, "R6/R7 gate_open model");
    chk(read_trig, m_trig != 0, "R3 read_trig model");
    chk(shp_true, m_shp > 0, "R8 shp_true model");
    chk(shp_comp, m_shp == 0, "R8 shp_comp model");
    chk(ext_vid, mode_special && (m_gate != 0) && vid_in, "R7 ext_vid model");
  endtask

  task automatic model_step();
    int g, expire, edge_v;
    g = (vid_in && exp_main() != 0) ? 1 : 0;
    edge_v = (g != 0 && m_prevg == 0) ? 1 : 0;
    expire = (m_dcnt == 1 && !dec_en) ? 1 : 0;
    if (dec_en || term_line || term_count || term_timing) m_gate = 0;
    else if (expire != 0) m_gate = 1;
    m_trig = expire;
    if (dec_en) m_dcnt = DLY;
    else if (m_dcnt > 0) m_dcnt--;
    if (m_shp > 0) m_shp--;
    else if (edge_v != 0) m_shp = SHP;
    m_prevg = g;
  endtask

  task automatic drive(input logic d, input logic tl, input logic tc, input logic tt,
                       input logic st, input logic ms, input logic ee, input logic v);
    dec_en = d; term_line = tl; term_count = tc; term_timing = tt;
    self_test = st; mode_special = ms; enc_en = ee; vid_in = v;
  endtask

  // inputs already driven; check, then advance one clock
  task automatic tick();
    #1;
    model_check();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0,0,0,0,0,0,0,0);
      tick();
    end
  endtask

  initial begin
    drive(0,0,0,0,0,0,0,0);
    rst = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(gate_open, 1'b0, "R1 reset gate_open");
    chk(shp_comp, 1'b1, "R1 reset shp_comp");
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(read_trig, 1'b0, "R1 read_trig after reset");
    chk(shp_true, 1'b0, "R1 shp_true after reset");
    chk(ext_vid, 1'b0, "R1 ext_vid after reset");

    // R3: exact delay
    drive(1,0,0,0,0,0,0,0); tick();
    idle(DLY - 1);
    #1; chk(gate_open, 1'b0, "R3 closed before delay end");
    idle(1);
    #1; chk(gate_open, 1'b1, "R3 open after delay");
    chk(read_trig, 1'b1, "R3 read trigger pulse");
    idle(1);
    #1; chk(read_trig, 1'b0, "R3 read trigger single cycle");

    // R8 / R9: shaper width and no retrigger
    drive(0,0,0,0,0,0,0,1); tick();
    drive(0,0,0,0,0,0,0,0); tick();
    drive(0,0,0,0,0,0,0,1); tick();
    #1; chk(shp_true, 1'b1, "R9 pulse still running");
    idle(SHP - 3);
    #1; chk(shp_true, 1'b1, "R8 last cycle of pulse");
    idle(1);
    #1; chk(shp_true, 1'b0, "R9 pulse not extended");
    chk(shp_comp, 1'b1, "R8 complement back high");

    // R7: special mode path
    drive(0,0,0,0,0,1,0,1); #1;
    chk(gate_open, 1'b0, "R7 main gate shut");
    chk(ext_vid, 1'b1, "R7 external video");
    tick();
    idle(1);
    #1; chk(shp_true, 1'b0, "R7 shaper untouched");

    // R5: terminate closes
    drive(0,0,1,0,0,0,0,0); tick();
    #1; chk(gate_open, 1'b0, "R5 count terminate closes");

    // R2: decode clears an open gate
    drive(1,0,0,0,0,0,0,0); tick();
    idle(DLY);
    drive(1,0,0,0,0,0,0,0); #1;
    chk(gate_open, 1'b1, "R2 gate open before strobe");
    tick();
    #1; chk(gate_open, 1'b0, "R2 decode clears gate");

    // R5: terminate beats expiry in the same cycle
    idle(DLY - 1);
    drive(0,0,0,1,0,0,0,0); tick();
    #1; chk(gate_open, 1'b0, "R5 terminate wins");
    chk(read_trig, 1'b1, "R5 trigger still issued");

    // R4: restart mid-delay
    drive(1,0,0,0,0,0,0,0); tick();
    idle(5);
    drive(1,0,0,0,0,0,0,0); tick();
    idle(DLY - 1);
    #1; chk(gate_open, 1'b0, "R4 restart extends delay");
    idle(1);
    #1; chk(gate_open, 1'b1, "R4 open after restarted delay");

    // R6: self-test uses encode enable
    drive(0,1,0,0,1,0,0,0); #1;
    chk(gate_open, 1'b0, "R6 enc_en low");
    tick();
    drive(0,0,0,0,1,0,1,0); #1;
    chk(gate_open, 1'b1, "R6 enc_en high with flag clear");
    tick();

    // random traffic against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 24) == 0, ($urandom % 50) == 0, ($urandom % 50) == 0,
            ($urandom % 50) == 0, ($urandom % 8) == 0, ($urandom % 10) == 0,
            ($urandom % 2) == 0, ($urandom % 3) == 0);
      tick();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule